// File: doc/BRIEF.md
# Interrupt Thread-Context Priority Arbiter

This block holds the interrupt context of one hardware thread for two hypervisor rings: a physical ring and a pool ring. Each ring keeps four pieces of state. The first is a bitmap of pending priority levels. The second is a current priority, which is the threshold written by software. The third is a pending priority, meaning the most favored pending level. The fourth is an exception flag, driven out as a per-ring interrupt line. Numerically lower priorities are more favored.

Software uses a command port. It can write a ring's current priority, accept the pending interrupt of a ring, or write the pool ring's context byte. Bit 7 of that byte marks the pool context as valid. The event side posts new pending levels into a ring through a separate port, and it can do so in the same cycle as a command.

When the physical ring's current priority is written and the pool context is valid, the pending levels of both rings compete for the physical ring. The ring that supplied the winning level is the one that receives the exception. All state changes appear one clock after the request.

Top module: `tctx_arb`

## Requirements
- R1: After the asynchronous active-low reset, both pending bitmaps are zero, both current priorities are 0, both pending priorities are 0xFF, the pool context byte is zero, and both interrupt outputs are low.
- R2: Priority level L (0 to 7) maps to bitmap bit 7−L. A pending priority is the lowest level whose bit is set, or 0xFF when the bitmap is empty.
- R3: A post ORs post_bits_i into the addressed ring's bitmap and reloads that ring's pending priority from the merged bitmap one cycle later.
- R4: Command op 0 stores cmd_data_i as the addressed ring's current priority and reloads that ring's pending priority from its bitmap one cycle later.
- R5: When op 0 addresses the physical ring (cmd_ring_i = 0) and bit 7 of the pool context byte is set, the physical pending priority becomes the smaller of the physical and pool pending levels. When that bit is clear, the pool bitmap is ignored.
- R6: An exception is raised on a ring only when the newly computed pending value is strictly less than the current priority it is judged against. An equal value raises nothing.
- R7: After op 0 on the physical ring, the exception is judged for the ring that supplied the winning level, using that ring's current priority. If the pool is strictly better, only the pool line can rise. On a tie, the physical ring wins.
- R8: Command op 1 (accept) clears the ring's exception. It also clears the bitmap bit of the ring's current priority when that priority is below 8. It leaves the pending priority unchanged.
- R9: A post and a command in the same cycle on the same ring act on the merged bitmap. An accept clears its bit from the merged bitmap, and a raise from the post wins over the accept's clear.
- R10: Command op 2 stores cmd_data_i as the pool context byte. Op 3 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 set priority, 1 accept, 2 pool context write, 3 no operation |
| cmd_ring_i | input | 1 | Command target: 0 physical, 1 pool |
| cmd_data_i | input | PW | Priority value or context byte |
| post_valid_i | input | 1 | Post strobe |
| post_ring_i | input | 1 | Post target: 0 physical, 1 pool |
| post_bits_i | input | NUM_PRIO | Pending levels to add |
| irq_o | output | 2 | Exception lines, bit 0 physical, bit 1 pool |
| ipb_phys_o | output | NUM_PRIO | Physical pending bitmap |
| ipb_pool_o | output | NUM_PRIO | Pool pending bitmap |
| cppr_phys_o | output | PW | Physical current priority |
| cppr_pool_o | output | PW | Pool current priority |
| pipr_phys_o | output | PW | Physical pending priority |
| pipr_pool_o | output | PW | Pool pending priority |
| pool_ctx_o | output | 8 | Pool context byte |

## Verification
A post and a command can land on the same ring in the same cycle. The cases that matter are an accept colliding with a post that brings a level better than the current priority, and a priority write colliding with a post into the same bitmap. The bench drives both strobes in one cycle. It then checks three things: that the accepted level's bit is gone from the merged bitmap, that the new bits are kept, and that the interrupt line stays high because the raise wins over the clear.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int unsigned NUM_RING  = 2;
  localparam int unsigned RING_PHYS = 0;
  localparam int unsigned RING_POOL = 1;
  localparam int unsigned CTX_W     = 8;
  localparam int unsigned CTX_VLD   = 7;

  typedef enum logic [1:0] {
    OP_SET_CPPR = 2'd0,
    OP_ACCEPT   = 2'd1,
    OP_CTX_WR   = 2'd2,
    OP_NOP      = 2'd3
  } tctx_op_e;
endpackage

// File: rtl/tctx_prio_enc.sv
module tctx_prio_enc #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned PW       = 8
) (
  input  logic [NUM_PRIO-1:0] ipb_i,
  output logic [PW-1:0]       pend_o
);
  // level l lives at bit NUM_PRIO-1-l; scan from worst to best so best wins
  always_comb begin
    pend_o = '1;
    for (int l = NUM_PRIO - 1; l >= 0; l--) begin
      if (ipb_i[NUM_PRIO-1-l]) pend_o = PW'(l);
    end
  end
endmodule

// File: rtl/tctx_pick.sv
module tctx_pick #(
  parameter int unsigned PW = 8
) (
  input  logic [PW-1:0] pend_phys_i,
  input  logic [PW-1:0] pend_pool_i,
  input  logic          pool_vld_i,
  output logic [PW-1:0] pmin_o,
  output logic          pool_wins_o
);
  // strict compare: a tie stays with the physical ring
  assign pool_wins_o = pool_vld_i && (pend_pool_i < pend_phys_i);
  assign pmin_o      = pool_wins_o ? pend_pool_i : pend_phys_i;
endmodule

// File: rtl/tctx_ring.sv
module tctx_ring #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned PW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                post_en_i,
  input  logic [NUM_PRIO-1:0] post_bits_i,
  input  logic                cppr_we_i,
  input  logic [PW-1:0]       cppr_i,
  input  logic                acc_i,
  input  logic                pipr_we_i,
  input  logic [PW-1:0]       pipr_i,
  input  logic                raise_i,
  output logic [NUM_PRIO-1:0] ipb_o,
  output logic [NUM_PRIO-1:0] ipb_mrg_o,
  output logic [PW-1:0]       cppr_o,
  output logic [PW-1:0]       pipr_o,
  output logic                exc_o
);
  localparam int unsigned IW = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;

  logic [NUM_PRIO-1:0] ipb_q, clr;
  logic [PW-1:0]       cppr_q, pipr_q;
  logic                exc_q;
  logic [IW-1:0]       lvl;

  assign lvl       = cppr_q[IW-1:0];
  assign ipb_mrg_o = ipb_q | (post_en_i ? post_bits_i : '0);

  always_comb begin
    clr = '0;
    if (cppr_q < PW'(NUM_PRIO)) clr[IW'(NUM_PRIO - 1) - lvl] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipb_q  <= '0;
      cppr_q <= '0;
      pipr_q <= '1;
      exc_q  <= 1'b0;
    end else begin
      ipb_q <= acc_i ? (ipb_mrg_o & ~clr) : ipb_mrg_o;
      if (cppr_we_i) cppr_q <= cppr_i;
      if (pipr_we_i) pipr_q <= pipr_i;
      if (raise_i)     exc_q <= 1'b1;
      else if (acc_i)  exc_q <= 1'b0;
    end
  end

  assign ipb_o  = ipb_q;
  assign cppr_o = cppr_q;
  assign pipr_o = pipr_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/tctx_arb.sv
module tctx_arb
  import tctx_pkg::*;
#(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned PW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic                cmd_ring_i,
  input  logic [PW-1:0]       cmd_data_i,
  input  logic                post_valid_i,
  input  logic                post_ring_i,
  input  logic [NUM_PRIO-1:0] post_bits_i,
  output logic [1:0]          irq_o,
  output logic [NUM_PRIO-1:0] ipb_phys_o,
  output logic [NUM_PRIO-1:0] ipb_pool_o,
  output logic [PW-1:0]       cppr_phys_o,
  output logic [PW-1:0]       cppr_pool_o,
  output logic [PW-1:0]       pipr_phys_o,
  output logic [PW-1:0]       pipr_pool_o,
  output logic [CTX_W-1:0]    pool_ctx_o
);
  tctx_op_e            op;
  logic                is_set, is_acc, is_ctx;
  logic [CTX_W-1:0]    ctx_q;

  logic [NUM_PRIO-1:0] ipb_q   [NUM_RING];
  logic [NUM_PRIO-1:0] ipb_mrg [NUM_RING];
  logic [PW-1:0]       cppr_q  [NUM_RING];
  logic [PW-1:0]       cppr_nx [NUM_RING];
  logic [PW-1:0]       pipr_q  [NUM_RING];
  logic [PW-1:0]       pend    [NUM_RING];
  logic [PW-1:0]       pipr_d  [NUM_RING];
  logic [NUM_RING-1:0] post_en, set_en, acc_en, pipr_we, raise, exc_q;

  logic [PW-1:0]       pmin, set_cand;
  logic                pool_wins, set_win;

  assign op     = tctx_op_e'(cmd_op_i);
  assign is_set = cmd_valid_i && (op == OP_SET_CPPR);
  assign is_acc = cmd_valid_i && (op == OP_ACCEPT);
  assign is_ctx = cmd_valid_i && (op == OP_CTX_WR);

  tctx_pick #(.PW(PW)) u_pick (
    .pend_phys_i (pend[RING_PHYS]),
    .pend_pool_i (pend[RING_POOL]),
    .pool_vld_i  (ctx_q[CTX_VLD]),
    .pmin_o      (pmin),
    .pool_wins_o (pool_wins)
  );

  // ring whose level won the priority write, and the value judged
  assign set_win  = cmd_ring_i ? 1'b1 : pool_wins;
  assign set_cand = cmd_ring_i ? pend[RING_POOL] : pmin;

  for (genvar r = 0; r < NUM_RING; r++) begin : g_ring
    assign post_en[r] = post_valid_i && (post_ring_i == 1'(r));
    assign set_en[r]  = is_set && (cmd_ring_i == 1'(r));
    assign acc_en[r]  = is_acc && (cmd_ring_i == 1'(r));
    assign cppr_nx[r] = set_en[r] ? cmd_data_i : cppr_q[r];
    assign pipr_we[r] = set_en[r] || post_en[r];
    assign pipr_d[r]  = set_en[r] ? ((r == RING_PHYS) ? pmin : pend[r]) : pend[r];
    assign raise[r]   = (post_en[r] && (pend[r] < cppr_nx[r])) ||
                        (is_set && (set_win == 1'(r)) && (set_cand < cppr_nx[r]));

    tctx_prio_enc #(.NUM_PRIO(NUM_PRIO), .PW(PW)) u_enc (
      .ipb_i  (ipb_mrg[r]),
      .pend_o (pend[r])
    );

    tctx_ring #(.NUM_PRIO(NUM_PRIO), .PW(PW)) u_ring (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .post_en_i   (post_en[r]),
      .post_bits_i (post_bits_i),
      .cppr_we_i   (set_en[r]),
      .cppr_i      (cmd_data_i),
      .acc_i       (acc_en[r]),
      .pipr_we_i   (pipr_we[r]),
      .pipr_i      (pipr_d[r]),
      .raise_i     (raise[r]),
      .ipb_o       (ipb_q[r]),
      .ipb_mrg_o   (ipb_mrg[r]),
      .cppr_o      (cppr_q[r]),
      .pipr_o      (pipr_q[r]),
      .exc_o       (exc_q[r])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctx_q <= '0;
    else if (is_ctx) ctx_q <= cmd_data_i[CTX_W-1:0];
  end

  assign irq_o       = exc_q;
  assign ipb_phys_o  = ipb_q[RING_PHYS];
  assign ipb_pool_o  = ipb_q[RING_POOL];
  assign cppr_phys_o = cppr_q[RING_PHYS];
  assign cppr_pool_o = cppr_q[RING_POOL];
  assign pipr_phys_o = pipr_q[RING_PHYS];
  assign pipr_pool_o = pipr_q[RING_POOL];
  assign pool_ctx_o  = ctx_q;
endmodule

// File: rtl/tctx_arb_chk.sv
module tctx_arb_chk #(
  parameter int unsigned NUM_PRIO = 8,
  parameter int unsigned PW       = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [1:0]          cmd_op_i,
  input logic                cmd_ring_i,
  input logic [PW-1:0]       cmd_data_i,
  input logic                post_valid_i,
  input logic                post_ring_i,
  input logic [1:0]          irq_o,
  input logic [NUM_PRIO-1:0] ipb_phys_o,
  input logic [NUM_PRIO-1:0] ipb_pool_o,
  input logic [PW-1:0]       cppr_phys_o,
  input logic [PW-1:0]       cppr_pool_o,
  input logic [PW-1:0]       pipr_phys_o,
  input logic [PW-1:0]       pipr_pool_o,
  input logic [7:0]          pool_ctx_o
);
  function automatic logic [PW-1:0] best_lvl(input logic [NUM_PRIO-1:0] b);
    for (int k = 0; k < NUM_PRIO; k++) if (b[NUM_PRIO-1-k]) return PW'(k);
    return '1;
  endfunction

  logic set_phys, acc_phys, no_post_phys, any_req;
  assign set_phys     = cmd_valid_i && cmd_op_i == 2'd0 && !cmd_ring_i;
  assign acc_phys     = cmd_valid_i && cmd_op_i == 2'd1 && !cmd_ring_i;
  assign no_post_phys = !(post_valid_i && !post_ring_i);
  assign any_req      = cmd_valid_i || post_valid_i;

  assert_cppr_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_phys |=> cppr_phys_o == $past(cmd_data_i));

  assert_pool_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_phys && no_post_phys && !pool_ctx_o[7] |=> pipr_phys_o == best_lvl($past(ipb_phys_o)));

  assert_pool_win_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_phys && !post_valid_i && pool_ctx_o[7] && best_lvl(ipb_pool_o) < best_lvl(ipb_phys_o)
    |=> pipr_phys_o == best_lvl($past(ipb_pool_o)) && irq_o[0] == $past(irq_o[0]));

  assert_acc_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_phys && no_post_phys |=> !irq_o[0] && $stable(pipr_phys_o));

  assert_irq_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) || $rose(irq_o[1]) |-> $past(any_req));

  assert_nop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_op_i == 2'd3 |=> $stable(cppr_phys_o) && $stable(cppr_pool_o) && $stable(pool_ctx_o));

  assert_pend_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pipr_phys_o < PW'(NUM_PRIO) || pipr_phys_o == '1) && (pipr_pool_o < PW'(NUM_PRIO) || pipr_pool_o == '1));
endmodule

bind tctx_arb tctx_arb_chk #(.NUM_PRIO(NUM_PRIO), .PW(PW)) u_chk (.*);

// File: tb/tb_tctx_arb.sv
`timescale 1ns/1ps
module tb_tctx_arb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = '0;
  logic       cmd_ring_i = 1'b0;
  logic [7:0] cmd_data_i = '0;
  logic       post_valid_i = 1'b0;
  logic       post_ring_i = 1'b0;
  logic [7:0] post_bits_i = '0;
  logic [1:0] irq_o;
  logic [7:0] ipb_phys_o, ipb_pool_o, cppr_phys_o, cppr_pool_o, pipr_phys_o, pipr_pool_o, pool_ctx_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tctx_arb dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_ring_i(cmd_ring_i), .cmd_data_i(cmd_data_i),
    .post_valid_i(post_valid_i), .post_ring_i(post_ring_i), .post_bits_i(post_bits_i),
    .irq_o(irq_o), .ipb_phys_o(ipb_phys_o), .ipb_pool_o(ipb_pool_o),
    .cppr_phys_o(cppr_phys_o), .cppr_pool_o(cppr_pool_o),
    .pipr_phys_o(pipr_phys_o), .pipr_pool_o(pipr_pool_o), .pool_ctx_o(pool_ctx_o)
  );

  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference state built from the requirements
  logic [7:0] m_ipb [2];
  logic [7:0] m_cppr[2];
  logic [7:0] m_pipr[2];
  logic [1:0] m_irq;
  logic [7:0] m_ctx;

  function automatic logic [7:0] lvl_of(input logic [7:0] b);
    for (int k = 0; k < 8; k++) if (b[7-k]) return 8'(k);
    return 8'hFF;
  endfunction

  function automatic logic [63:0] snap_dut();
    return {ipb_phys_o, ipb_pool_o, cppr_phys_o, cppr_pool_o, pipr_phys_o, pipr_pool_o, pool_ctx_o, 6'd0, irq_o};
  endfunction

  function automatic logic [63:0] snap_model();
    return {m_ipb[0], m_ipb[1], m_cppr[0], m_cppr[1], m_pipr[0], m_pipr[1], m_ctx, 6'd0, m_irq};
  endfunction

  task automatic hcheck(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply one request for one cycle and queue the expected state
  task automatic drive(input bit cv, input logic [1:0] op, input bit cr, input logic [7:0] cd,
                       input bit pv, input bit pr, input logic [7:0] pb, input string tag);
    logic [7:0] mrg[2];
    logic [7:0] cn[2];
    logic [1:0] up;
    logic [7:0] cand;
    int         w;
    exp_t       e;
    @(negedge clk);
    cmd_valid_i = cv; cmd_op_i = op; cmd_ring_i = cr; cmd_data_i = cd;
    post_valid_i = pv; post_ring_i = pr; post_bits_i = pb;
    for (int r = 0; r < 2; r++) begin
      mrg[r] = m_ipb[r] | ((pv && pr == 1'(r)) ? pb : 8'h00);
      cn[r]  = (cv && op == 2'd0 && cr == 1'(r)) ? cd : m_cppr[r];
    end
    up = 2'b00;
    if (pv) begin
      m_pipr[pr] = lvl_of(mrg[pr]);
      if (m_pipr[pr] < cn[pr]) up[pr] = 1'b1;
    end
    if (cv && op == 2'd0) begin
      if (!cr) begin
        cand = lvl_of(mrg[0]); w = 0;
        if (m_ctx[7] && lvl_of(mrg[1]) < cand) begin cand = lvl_of(mrg[1]); w = 1; end
      end else begin
        cand = lvl_of(mrg[1]); w = 1;
      end
      m_pipr[cr] = cand;
      if (cand < cn[w]) up[w] = 1'b1;
    end
    if (cv && op == 2'd1) begin
      if (m_cppr[cr] < 8) mrg[cr][7 - m_cppr[cr][2:0]] = 1'b0;
      m_irq[cr] = 1'b0;
    end
    if (cv && op == 2'd2) m_ctx = cd;
    m_irq = m_irq | up;
    m_ipb[0] = mrg[0]; m_ipb[1] = mrg[1];
    m_cppr[0] = cn[0]; m_cppr[1] = cn[1];
    e.val = snap_model(); e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    cmd_valid_i = 1'b0; post_valid_i = 1'b0;
  endtask

  // monitor: compare after each edge that has a queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        hcheck(e.tag, snap_dut(), e.val);
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_ipb[0] = 0; m_ipb[1] = 0; m_cppr[0] = 0; m_cppr[1] = 0;
    m_pipr[0] = 8'hFF; m_pipr[1] = 8'hFF; m_irq = 0; m_ctx = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    hcheck("R1", snap_dut(), {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00});

    drive(0, 0, 0, 8'h00, 1, 0, 8'h20, "R3");
    hcheck("R2", {56'd0, pipr_phys_o}, 64'd2);
    drive(0, 0, 0, 8'h00, 1, 0, 8'h01, "R3");
    drive(1, 0, 0, 8'h05, 0, 0, 8'h00, "R4");
    hcheck("R6", {62'd0, irq_o}, 64'd1);
    drive(1, 1, 0, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 0, 0, 8'h02, 0, 0, 8'h00, "R6");
    hcheck("R6", {62'd0, irq_o}, 64'd0);
    drive(1, 1, 0, 8'h00, 0, 0, 8'h00, "R8");
    hcheck("R8", {48'd0, ipb_phys_o, pipr_phys_o}, {48'd0, 8'h01, 8'h02});
    drive(1, 0, 0, 8'hFF, 0, 0, 8'h00, "R4");
    drive(1, 1, 0, 8'h00, 0, 0, 8'h00, "R8");
    drive(0, 0, 0, 8'h00, 1, 1, 8'h80, "R3");
    drive(1, 0, 0, 8'hFF, 0, 0, 8'h00, "R5");
    hcheck("R5", {56'd0, pipr_phys_o}, 64'd7);
    drive(1, 1, 0, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 2, 0, 8'h80, 0, 0, 8'h00, "R10");
    hcheck("R10", {56'd0, pool_ctx_o}, 64'h80);
    drive(1, 0, 1, 8'h04, 0, 0, 8'h00, "R6");
    drive(1, 1, 1, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 0, 0, 8'hFF, 0, 0, 8'h00, "R7");
    hcheck("R7", {62'd0, irq_o}, 64'd2);
    hcheck("R5", {56'd0, pipr_phys_o}, 64'd0);
    drive(1, 1, 1, 8'h00, 0, 0, 8'h00, "R8");
    drive(0, 0, 0, 8'h00, 1, 0, 8'h80, "R3");
    drive(1, 1, 0, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 0, 0, 8'hFF, 0, 0, 8'h00, "R7");
    hcheck("R7", {62'd0, irq_o}, 64'd1);
    drive(1, 0, 0, 8'h05, 0, 0, 8'h00, "R4");
    drive(1, 1, 0, 8'h00, 1, 0, 8'h04, "R9");
    hcheck("R9", {48'd0, ipb_phys_o, 6'd0, irq_o}, {48'd0, 8'h81, 8'h01});
    drive(1, 0, 1, 8'h01, 1, 1, 8'h40, "R9");
    hcheck("R9", {48'd0, ipb_pool_o, 6'd0, irq_o}, {48'd0, 8'hC0, 8'h03});
    drive(1, 3, 0, 8'h55, 0, 0, 8'h00, "R10");
    drive(1, 1, 1, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 0, 1, 8'h00, 0, 0, 8'h00, "R4");
    drive(1, 1, 1, 8'h00, 0, 0, 8'h00, "R8");
    drive(1, 0, 1, 8'h00, 0, 0, 8'h00, "R2");
    hcheck("R2", {48'd0, ipb_pool_o, pipr_pool_o}, {48'd0, 8'h00, 8'hFF});

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule